// File: doc/BRIEF.md
# Level-Sensitive Primary Interrupt Controller with Winner Selector

This block gathers 64 level-sensitive interrupt lines into one request to the processor core. Every line owns a 32-bit configuration word, reachable through a simple write-strobe and address register port. Only the low seven bits of that word are kept. A line takes part in arbitration only while one particular bit of its field is set: the route-to-core bit of the enable pattern that the chosen variant uses. Software turns a line on by writing the enable pattern into the field, and turns it off by writing zero.

Every cycle the controller finds the lowest-numbered line that is both high and enabled. It registers the result into a read-only select word, which holds a pending flag and the six-bit number of the winning line. The core request output is a registered copy of the same pending flag. A parameter picks the variant: variant 1 uses enable pattern 0x20, route bit 5 and a select word at 0x104. Variant 0 uses pattern 0x51, route bit 4 and a select word at 0x10C. Lines that come from secondary multiplexers are wired in as ordinary inputs.

Top module: `icu_primary`

## Requirements
- R1: After reset every configuration field reads 0, so all lines are disabled, and both the select word and `irq_o` read 0.
- R2: A write to byte address 4*n (n from 0 to 63) stores `wdata_i[6:0]` as the field of line n. Reading that address returns the field in bits 6:0, with bits 31:7 at 0.
- R3: A line whose field is 0 never shows as pending, whatever its input does.
- R4: A line is enabled exactly when bit ROUTE_BIT of its field is 1 (bit 5 in variant 1). The other six field bits have no effect on arbitration.
- R5: The select word is read at SEL_ADDR (0x104 in variant 1). Its bit 6 is 1 exactly when at least one line was both high and enabled at the previous clock edge. Bits 5:0 then hold that line's number, and bits 31:7 read 0.
- R6: When several enabled lines are high together, the select word reports the lowest-numbered one.
- R7: Lines are level-sensitive. Once a line's input falls, or its field is cleared, it stops showing as pending at the next clock edge.
- R8: `irq_o` always equals bit 6 of the select word.
- R9: While bit 6 of the select word is 0, bits 5:0 read 0.
- R10: Writes to the select address and to addresses outside the configuration range and the select word change no state. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Level interrupt lines, bit n is line n |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 12 | Byte address for both reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Registered interrupt request to the core |

## Verification
The checker watches four things on every cycle. It checks that `irq_o` tracks the select word's pending flag. It checks that an idle select word carries a zero number. It checks that the reported line was high and enabled on the previous cycle, and that no lower-numbered line was. It also checks that the pending flag agrees with the set of live lines.

Some behaviour only the bench's scenarios can show. These are field storage and readback widths, the route-bit-only enable decoding, and disabling by writing zero. They also include the lack of effect of stray writes, and the one-cycle drop after a line falls.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int FIELD_W = 7;
  localparam int SEL_W   = 7;

  // route-to-core bit inside the enable pattern of each variant
  function automatic int route_bit(input int variant);
    return (variant != 0) ? 5 : 4;
  endfunction

  function automatic logic [FIELD_W-1:0] enable_pattern(input int variant);
    return (variant != 0) ? 7'h20 : 7'h51;
  endfunction

  function automatic logic [11:0] select_offset(input int variant);
    return (variant != 0) ? 12'h104 : 12'h10C;
  endfunction
endpackage

// File: rtl/icu_cfg_bank.sv
module icu_cfg_bank #(
  parameter int NUM_SRC   = 64,
  parameter int FIELD_W   = 7,
  parameter int ROUTE_BIT = 5,
  localparam int IDX_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [FIELD_W-1:0] wr_field,
  output logic [FIELD_W-1:0] field_o [NUM_SRC],
  output logic [NUM_SRC-1:0] enabled_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
    logic [FIELD_W-1:0] field_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) field_q <= '0;
      else if (wr_hit && (wr_idx == IDX_W'(g))) field_q <= wr_field;
    end
    assign field_o[g]   = field_q;
    assign enabled_o[g] = field_q[ROUTE_BIT];
  end
endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter #(
  parameter int NUM_SRC = 64,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] live_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   win_o
);
  function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign any_o = |live_i;
  assign win_o = lowest_set(live_i);
endmodule

// File: rtl/icu_selector.sv
module icu_selector #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_i,
  input  logic [IDX_W-1:0] win_i,
  output logic [IDX_W:0]   sel_o,
  output logic             irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_o <= '0;
      irq_o <= 1'b0;
    end else begin
      sel_o <= {any_i, any_i ? win_i : '0};
      irq_o <= any_i;
    end
  end
endmodule

// File: rtl/icu_primary.sv
module icu_primary #(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12,
  parameter int VARIANT = 1,
  localparam int IDX_W     = $clog2(NUM_SRC),
  localparam int FIELD_W   = icu_pkg::FIELD_W,
  localparam int ROUTE_BIT = icu_pkg::route_bit(VARIANT),
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(icu_pkg::select_offset(VARIANT))
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o
);
  logic [FIELD_W-1:0] field   [NUM_SRC];
  logic [NUM_SRC-1:0] enabled;
  logic [NUM_SRC-1:0] live;
  logic               cfg_hit;
  logic [IDX_W-1:0]   cfg_idx;
  logic               arb_any;
  logic [IDX_W-1:0]   arb_win;
  logic [IDX_W:0]     sel_q;

  assign cfg_hit = (addr_i[1:0] == 2'b00) &&
                   ((32'(addr_i) >> 2) < 32'(NUM_SRC));
  assign cfg_idx = addr_i[2 +: IDX_W];
  assign live    = src_i & enabled;

  icu_cfg_bank #(.NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W), .ROUTE_BIT(ROUTE_BIT)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_hit(wr_en_i && cfg_hit), .wr_idx(cfg_idx), .wr_field(wdata_i[FIELD_W-1:0]),
    .field_o(field), .enabled_o(enabled)
  );

  icu_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .live_i(live), .any_o(arb_any), .win_o(arb_win)
  );

  icu_selector #(.IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .any_i(arb_any), .win_i(arb_win),
    .sel_o(sel_q), .irq_o(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == SEL_ADDR)  rdata_o = 32'(sel_q);
    else if (cfg_hit)        rdata_o = 32'(field[cfg_idx]);
  end
endmodule

// File: rtl/icu_primary_chk.sv
module icu_primary_chk #(
  parameter int NUM_SRC = 64,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic [NUM_SRC-1:0] enabled,
  input logic [IDX_W:0]     sel_q,
  input logic               irq_o
);
  logic [NUM_SRC-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= src_i & enabled;
  end

  logic [NUM_SRC-1:0] below_win;
  assign below_win = (NUM_SRC'(1) << sel_q[IDX_W-1:0]) - NUM_SRC'(1);

  assert_irq_tracks_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == sel_q[IDX_W]);
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q[IDX_W] |-> (sel_q[IDX_W-1:0] == '0));
  assert_flag_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q[IDX_W] == (seen_q != '0));
  assert_winner_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q[IDX_W] |-> seen_q[sel_q[IDX_W-1:0]]);
  assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q[IDX_W] |-> ((seen_q & below_win) == '0));
endmodule

bind icu_primary icu_primary_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .enabled(enabled),
  .sel_q(sel_q), .irq_o(irq_o)
);

// File: tb/icu_primary_bench.sv
module icu_primary_bench;
  localparam logic [11:0] SEL_ADDR = 12'h104;
  localparam logic [31:0] ON_WORD  = 32'h0000_0020;
  localparam logic [31:0] OFF_WORD = 32'h0000_005F;

  typedef struct packed {
    logic [63:0] src;
    logic [63:0] en;
    logic [6:0]  exp_sel;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{src:64'h0,                   en:64'hFFFF_FFFF_FFFF_FFFF, exp_sel:7'h00},
    '{src:64'h20,                  en:64'hFFFF_FFFF_FFFF_FFFF, exp_sel:7'h45},
    '{src:64'h408,                 en:64'hFFFF_FFFF_FFFF_FFFF, exp_sel:7'h43},
    '{src:64'h408,                 en:64'h400,                 exp_sel:7'h4A},
    '{src:64'h8000_0000_0000_0000, en:64'hFFFF_FFFF_FFFF_FFFF, exp_sel:7'h7F},
    '{src:64'hFFFF_FFFF_FFFF_FFFF, en:64'h1,                   exp_sel:7'h40},
    '{src:64'hFFFF_FFFF_FFFF_FFFF, en:64'h0,                   exp_sel:7'h00},
    '{src:64'h8000_0000_0000_0001, en:64'h8000_0000_0000_0000, exp_sel:7'h7F}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_i = '0;
  logic        wr_en_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  icu_primary u_icu_primary (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    rd(12'h000, d); check("R1 cfg0", d, 32'h0);
    rd(12'h0FC, d); check("R1 cfg63", d, 32'h0);
    rd(SEL_ADDR, d); check("R1 sel", d, 32'h0);
    check("R1 irq", 32'(irq_o), 32'h0);
    // R3: lines high with zero field never pending
    src_i = '1;
    @(negedge clk);
    rd(SEL_ADDR, d); check("R3 zero field idle", d, 32'h0);
    src_i = '0;

    // R4 R5 R6 R9: table walk
    foreach (VECS[v]) begin
      for (int i = 0; i < 64; i++)
        wr(12'(i * 4), VECS[v].en[i] ? ON_WORD : OFF_WORD);
      src_i = VECS[v].src;
      @(negedge clk);
      rd(SEL_ADDR, d); check("R6 R4 R5 R9 table sel", d, 32'(VECS[v].exp_sel));
      check("R8 irq vs sel", 32'(irq_o), 32'(VECS[v].exp_sel[6]));
    end

    // R2: storage width and readback
    wr(12'h01C, 32'hFFFF_FFFF);
    rd(12'h01C, d); check("R2 field width", d, 32'h7F);
    wr(12'h01C, 32'h1234_5655);
    rd(12'h01C, d); check("R2 field value", d, 32'h55);

    // R4: all other bits set, route bit set -> enabled
    for (int i = 0; i < 64; i++) wr(12'(i * 4), 32'h0);
    wr(12'h028, 32'h7F);
    src_i = 64'h400;
    @(negedge clk);
    rd(SEL_ADDR, d); check("R4 full field enabled", d, 32'h4A);

    // R7: line falls -> idle at next edge
    src_i = 64'h0;
    @(negedge clk);
    rd(SEL_ADDR, d); check("R7 level drop", d, 32'h0);
    check("R8 irq low", 32'(irq_o), 32'h0);
    src_i = 64'h400;
    @(negedge clk);
    rd(SEL_ADDR, d); check("R7 level rise", d, 32'h4A);
    check("R8 irq high", 32'(irq_o), 32'h1);

    // R3: writing zero disables
    wr(12'h028, 32'h0);
    @(negedge clk);
    rd(SEL_ADDR, d); check("R3 cleared field", d, 32'h0);

    // R10: stray writes
    wr(12'h028, ON_WORD);
    wr(SEL_ADDR, 32'h0);
    rd(SEL_ADDR, d); check("R10 sel write ignored", d, 32'h4A);
    wr(12'h200, 32'h7F);
    rd(12'h200, d); check("R10 unmapped read", d, 32'h0);
    rd(12'h000, d); check("R10 cfg0 untouched", d, 32'h0);
    rd(12'h028, d); check("R10 cfg10 untouched", d, 32'h20);
    src_i = '0;

    done = 1;
    summary();
  end
endmodule